// File: doc/BRIEF.md
# Prefetch-Aware Batching Request Scheduler

This block picks which buffered memory read each bank of a shared DRAM controller serves next. Several cores send both demand reads and prefetch reads into one shared request buffer. Each request carries a thread number, a target bank, a prefetch flag and a tag. The block tracks the relative age of all held requests. Every bank has its own valid/ready grant port, and each cycle at most one request is offered per bank.

Fairness between threads comes from batches. When no batch member is left in the buffer, a new batch is formed. For each thread, the batch takes up to a fixed number of that thread's oldest eligible requests. Demand reads are always eligible. A prefetch is eligible only if its core's prefetcher is flagged accurate at the moment the batch forms.

A second per-core flag marks cores with light memory traffic. When boosting is enabled, demand reads from those cores go ahead of everything else. Both per-core flag sets are captured when a batch forms and stay fixed until the next batch.

Top module: `pf_batch_sched`

## Requirements
- R1: After reset is released (two clock edges for internal release), the block shows `in_ready` high and no `gnt_valid` bit set.
- R2: The buffer holds 16 requests. With 16 held, `in_ready` is low, and an `in_valid` pulse in that state stores nothing.
- R3: Each bank offers at most one request at a time. A request leaves only on a cycle with its bank's `gnt_valid` and `gnt_ready` both high. Until then it stays offered.
- R4: A batch forms on the first clock edge at which the buffer holds requests but none of them is marked. It marks, per thread, at most 2 of that thread's oldest eligible requests.
- R5: A demand request (`in_pref`=0) is always eligible for marking.
- R6: A prefetch (`in_pref`=1) is marked only if `core_accurate[thread]` is 1 at batch formation. Otherwise it stays unmarked.
- R7: A request that arrives while marked requests remain stays unmarked until a later batch forms.
- R8: Per bank, priority is: boosted demand, then marked over unmarked, then demand over prefetch. `gnt_marked` reports the marked state of the offered request.
- R9: With `boost_en`=1, a demand from a core whose `core_light` bit was 1 at the last batch formation outranks every other request in its bank, including marked prefetches. With `boost_en`=0 there is no boost.
- R10: Requests of one thread to different banks are offered and retired in the same cycle.
- R11: Among requests of equal priority class in one bank, the oldest is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| boost_en | input | 1 | Enables demand boosting for light-traffic cores |
| core_accurate | input | 4 | Per-core prefetch accuracy flag, sampled at batch formation |
| core_light | input | 4 | Per-core light-traffic flag, sampled at batch formation |
| in_valid | input | 1 | New request present |
| in_ready | output | 1 | Buffer can accept a request |
| in_thread | input | 2 | Issuing thread of the new request |
| in_bank | input | 2 | Target bank of the new request |
| in_pref | input | 1 | 1 = prefetch, 0 = demand |
| in_tag | input | 4 | Caller identifier carried to the grant |
| gnt_valid | output | 4 | Per bank: a request is offered |
| gnt_ready | input | 4 | Per bank: the offered request is taken this cycle |
| gnt_thread | output | 8 | Per bank thread of the offered request (2 bits per bank) |
| gnt_tag | output | 16 | Per bank tag of the offered request (4 bits per bank) |
| gnt_pref | output | 4 | Per bank prefetch flag of the offered request |
| gnt_marked | output | 4 | Per bank batch-marked flag of the offered request |

## Verification
The assertions check the buffer accounting on every cycle, using an occupancy count built only from the port handshakes:
- back-pressure at 16 entries and no overflow;
- no more offers than held requests;
- an offer that is not taken persists.

Which request wins in a bank, and whether it is marked, depends on flags sampled at batch formation and on arrival order. Only the bench scenarios can show that. They cover the ordering pairs, the per-thread cap, late arrivals during a batch, and same-cycle grants across banks.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int unsigned PFS_THREADS = 4;
  localparam int unsigned PFS_BANKS   = 4;
  localparam int unsigned PFS_DEPTH   = 16;
  localparam int unsigned PFS_CAP     = 2;
  localparam int unsigned PFS_TAG_W   = 4;

  // priority class, most significant field decides first
  typedef struct packed {
    logic boosted;
    logic marked;
    logic demand;
  } prio_t;

  function automatic prio_t mk_prio(input logic boost, input logic mark, input logic dem);
    prio_t p;
    p.boosted = boost;
    p.marked  = mark;
    p.demand  = dem;
    return p;
  endfunction
endpackage

// File: rtl/pfs_req_buf.sv
module pfs_req_buf #(
  parameter int DEPTH = 16,
  parameter int TW    = 2,
  parameter int BW    = 2,
  parameter int GW    = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            push,
  input  logic [TW-1:0]                   push_thr,
  input  logic [BW-1:0]                   push_bnk,
  input  logic                            push_pref,
  input  logic [GW-1:0]                   push_tag,
  input  logic [DEPTH-1:0]                deq,
  output logic                            full,
  output logic [DEPTH-1:0]                vld,
  output logic [DEPTH-1:0][TW-1:0]        thr,
  output logic [DEPTH-1:0][BW-1:0]        bnk,
  output logic [DEPTH-1:0]                pref,
  output logic [DEPTH-1:0][GW-1:0]        tag,
  output logic [DEPTH-1:0][DEPTH-1:0]     older
);
  logic [DEPTH-1:0]            vld_q, vld_d, slot_oh;
  logic [DEPTH-1:0][DEPTH-1:0] older_q, older_d;
  logic                        found;

  always_comb begin
    slot_oh = '0;
    found   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        slot_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    vld_d   = (vld_q & ~deq) | (push ? slot_oh : '0);
    older_d = older_q;
    for (int j = 0; j < DEPTH; j++) begin
      if (push && slot_oh[j]) begin
        for (int i = 0; i < DEPTH; i++) begin
          older_d[j][i] = 1'b0;
          older_d[i][j] = vld_q[i] & ~deq[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      older_q <= '0;
    end else begin
      vld_q   <= vld_d;
      older_q <= older_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && slot_oh[i]) begin
        thr[i]  <= push_thr;
        bnk[i]  <= push_bnk;
        pref[i] <= push_pref;
        tag[i]  <= push_tag;
      end
    end
  end

  assign full  = &vld_q;
  assign vld   = vld_q;
  assign older = older_q;
endmodule

// File: rtl/pfs_batch_mark.sv
module pfs_batch_mark #(
  parameter int DEPTH = 16,
  parameter int NT    = 4,
  parameter int TW    = 2,
  parameter int CAP   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DEPTH-1:0]            vld,
  input  logic [DEPTH-1:0][TW-1:0]    thr,
  input  logic [DEPTH-1:0]            pref,
  input  logic [DEPTH-1:0][DEPTH-1:0] older,
  input  logic [DEPTH-1:0]            deq,
  input  logic [NT-1:0]               acc_in,
  input  logic [NT-1:0]               light_in,
  output logic [DEPTH-1:0]            mark,
  output logic [NT-1:0]               light
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]          mark_q, mark_d, elig, sel;
  logic [DEPTH-1:0][CW-1:0]  rank;
  logic [NT-1:0]             light_q, light_d;
  logic                      form;

  always_comb begin
    form = ~(|(vld & mark_q)) & (|vld);
    for (int i = 0; i < DEPTH; i++)
      elig[i] = vld[i] & (~pref[i] | acc_in[thr[i]]);
    for (int i = 0; i < DEPTH; i++) begin
      rank[i] = '0;
      for (int j = 0; j < DEPTH; j++)
        if (elig[j] && thr[j] == thr[i] && older[j][i])
          rank[i] = rank[i] + 1'b1;
      sel[i] = elig[i] && (rank[i] < CW'(CAP));
    end
    mark_d  = form ? (sel & ~deq) : (mark_q & ~deq);
    light_d = form ? light_in : light_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q  <= '0;
      light_q <= '0;
    end else begin
      mark_q  <= mark_d;
      light_q <= light_d;
    end
  end

  assign mark  = mark_q;
  assign light = light_q;
endmodule

// File: rtl/pfs_bank_pick.sv
module pfs_bank_pick #(
  parameter int DEPTH   = 16,
  parameter int NT      = 4,
  parameter int TW      = 2,
  parameter int BW      = 2,
  parameter int BANK_ID = 0
) (
  input  logic [DEPTH-1:0]            vld,
  input  logic [DEPTH-1:0][TW-1:0]    thr,
  input  logic [DEPTH-1:0][BW-1:0]    bnk,
  input  logic [DEPTH-1:0]            pref,
  input  logic [DEPTH-1:0]            mark,
  input  logic [DEPTH-1:0][DEPTH-1:0] older,
  input  logic [NT-1:0]               light,
  input  logic                        boost_en,
  output logic [DEPTH-1:0]            pick,
  output logic                        any
);
  logic [DEPTH-1:0]  cand;
  pfs_pkg::prio_t    key [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cand[i] = vld[i] && (bnk[i] == BW'(BANK_ID));
      key[i]  = pfs_pkg::mk_prio(boost_en & ~pref[i] & light[thr[i]], mark[i], ~pref[i]);
    end
    for (int i = 0; i < DEPTH; i++) begin
      pick[i] = cand[i];
      for (int j = 0; j < DEPTH; j++)
        if (j != i && cand[j] &&
            (key[j] > key[i] || (key[j] == key[i] && older[j][i])))
          pick[i] = 1'b0;
    end
    any = |cand;
  end
endmodule

// File: rtl/pf_batch_sched.sv
module pf_batch_sched #(
  parameter int NTHREAD = pfs_pkg::PFS_THREADS,
  parameter int NBANK   = pfs_pkg::PFS_BANKS,
  parameter int DEPTH   = pfs_pkg::PFS_DEPTH,
  parameter int CAP     = pfs_pkg::PFS_CAP,
  parameter int TAG_W   = pfs_pkg::PFS_TAG_W,
  localparam int TW     = $clog2(NTHREAD),
  localparam int BW     = $clog2(NBANK)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  boost_en,
  input  logic [NTHREAD-1:0]    core_accurate,
  input  logic [NTHREAD-1:0]    core_light,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [TW-1:0]         in_thread,
  input  logic [BW-1:0]         in_bank,
  input  logic                  in_pref,
  input  logic [TAG_W-1:0]      in_tag,
  output logic [NBANK-1:0]      gnt_valid,
  input  logic [NBANK-1:0]      gnt_ready,
  output logic [NBANK*TW-1:0]   gnt_thread,
  output logic [NBANK*TAG_W-1:0] gnt_tag,
  output logic [NBANK-1:0]      gnt_pref,
  output logic [NBANK-1:0]      gnt_marked
);
  logic [1:0]                   rst_pipe;
  logic                         rst_i, full, push;
  logic [DEPTH-1:0]             vld, pref, mark, deq;
  logic [DEPTH-1:0][TW-1:0]     thr;
  logic [DEPTH-1:0][BW-1:0]     bnk;
  logic [DEPTH-1:0][TAG_W-1:0]  tag;
  logic [DEPTH-1:0][DEPTH-1:0]  older;
  logic [NTHREAD-1:0]           light;
  logic [NBANK-1:0][DEPTH-1:0]  retire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i    = rst_pipe[1];
  assign in_ready = rst_i & ~full;
  assign push     = in_valid & in_ready;

  pfs_req_buf #(.DEPTH(DEPTH), .TW(TW), .BW(BW), .GW(TAG_W)) u_buf (
    .clk(clk), .rst_n(rst_i), .push(push), .push_thr(in_thread), .push_bnk(in_bank),
    .push_pref(in_pref), .push_tag(in_tag), .deq(deq), .full(full), .vld(vld),
    .thr(thr), .bnk(bnk), .pref(pref), .tag(tag), .older(older));

  pfs_batch_mark #(.DEPTH(DEPTH), .NT(NTHREAD), .TW(TW), .CAP(CAP)) u_mark (
    .clk(clk), .rst_n(rst_i), .vld(vld), .thr(thr), .pref(pref), .older(older),
    .deq(deq), .acc_in(core_accurate), .light_in(core_light), .mark(mark), .light(light));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DEPTH-1:0]  pick;
    logic              any;
    logic [TAG_W-1:0]  t_or;
    logic [TW-1:0]     h_or;
    logic              p_or, m_or;

    pfs_bank_pick #(.DEPTH(DEPTH), .NT(NTHREAD), .TW(TW), .BW(BW), .BANK_ID(b)) u_pick (
      .vld(vld), .thr(thr), .bnk(bnk), .pref(pref), .mark(mark), .older(older),
      .light(light), .boost_en(boost_en), .pick(pick), .any(any));

    always_comb begin
      t_or = '0;
      h_or = '0;
      p_or = 1'b0;
      m_or = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (pick[i]) begin
          t_or = t_or | tag[i];
          h_or = h_or | thr[i];
          p_or = p_or | pref[i];
          m_or = m_or | mark[i];
        end
      end
    end

    assign gnt_valid[b]                = any;
    assign gnt_tag[b*TAG_W +: TAG_W]   = t_or;
    assign gnt_thread[b*TW +: TW]      = h_or;
    assign gnt_pref[b]                 = p_or;
    assign gnt_marked[b]               = m_or;
    assign retire[b] = pick & {DEPTH{any & gnt_ready[b]}};
  end

  always_comb begin
    deq = '0;
    for (int b = 0; b < NBANK; b++) deq = deq | retire[b];
  end
endmodule

// File: rtl/pfs_sched_chk.sv
module pfs_sched_chk #(
  parameter int DEPTH = 16,
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [NBANK-1:0] gnt_valid,
  input logic [NBANK-1:0] gnt_ready
);
  localparam int OW = $clog2(DEPTH + 1) + 1;

  logic [OW-1:0] occ_q, occ_d;

  always_comb begin
    occ_d = occ_q + OW'(in_valid & in_ready);
    for (int b = 0; b < NBANK; b++)
      occ_d = occ_d - OW'(gnt_valid[b] & gnt_ready[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == OW'(DEPTH)) |-> !in_ready); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(DEPTH)); // R2

  AST_OFFER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    OW'($countones(gnt_valid)) <= occ_q); // R3

  for (genvar b = 0; b < NBANK; b++) begin : g_hold
    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid[b] && !gnt_ready[b]) |=> gnt_valid[b]); // R3
  end
endmodule

bind pf_batch_sched pfs_sched_chk #(.DEPTH(DEPTH), .NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .gnt_valid(gnt_valid), .gnt_ready(gnt_ready));

// File: tb/pf_batch_sched_test.sv
`timescale 1ns/1ps
module pf_batch_sched_test;
  logic        clk = 1'b0;
  logic        rst_n, boost_en, in_valid, in_ready, in_pref;
  logic [3:0]  core_accurate, core_light, gnt_valid, gnt_ready, gnt_pref, gnt_marked;
  logic [1:0]  in_thread, in_bank;
  logic [3:0]  in_tag;
  logic [7:0]  gnt_thread;
  logic [15:0] gnt_tag;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  pf_batch_sched uut (
    .clk(clk), .rst_n(rst_n), .boost_en(boost_en), .core_accurate(core_accurate),
    .core_light(core_light), .in_valid(in_valid), .in_ready(in_ready),
    .in_thread(in_thread), .in_bank(in_bank), .in_pref(in_pref), .in_tag(in_tag),
    .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_thread(gnt_thread),
    .gnt_tag(gnt_tag), .gnt_pref(gnt_pref), .gnt_marked(gnt_marked));

  // A is pushed first (older), B second; both to bank 0
  typedef struct packed {
    logic [1:0] at; logic ap; logic [1:0] bt; logic bp;
    logic [3:0] acc; logic [3:0] lt; logic bst; logic [3:0] etag; logic emk;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'd0, 1'b0, 2'd1, 1'b0, 4'h0, 4'h0, 1'b0, 4'd1, 1'b1},  // R11 age decides
    '{2'd0, 1'b1, 2'd1, 1'b0, 4'h0, 4'h0, 1'b0, 4'd2, 1'b1},  // R5 R6 demand marked, prefetch not
    '{2'd0, 1'b1, 2'd1, 1'b1, 4'h1, 4'h0, 1'b0, 4'd1, 1'b1},  // R6 accurate prefetch marked
    '{2'd0, 1'b1, 2'd1, 1'b0, 4'hF, 4'h0, 1'b0, 4'd2, 1'b1},  // R8 demand over prefetch
    '{2'd0, 1'b0, 2'd1, 1'b0, 4'h0, 4'h2, 1'b1, 4'd2, 1'b1},  // R9 boost on
    '{2'd0, 1'b0, 2'd1, 1'b0, 4'h0, 4'h2, 1'b0, 4'd1, 1'b1},  // R9 boost off
    '{2'd1, 1'b1, 2'd0, 1'b0, 4'h2, 4'h1, 1'b1, 4'd2, 1'b1},  // R9 boost over marked prefetch
    '{2'd2, 1'b0, 2'd2, 1'b0, 4'h0, 4'h0, 1'b0, 4'd1, 1'b1},  // R11 same thread
    '{2'd0, 1'b1, 2'd0, 1'b1, 4'h0, 4'h0, 1'b0, 4'd1, 1'b0}   // R6 both unmarked
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; gnt_ready = '0;
    core_accurate = '0; core_light = '0; boost_en = 1'b0;
    in_thread = '0; in_bank = '0; in_pref = 1'b0; in_tag = '0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic push(input logic [1:0] t, input logic [1:0] b, input logic p, input logic [3:0] g);
    in_thread = t; in_bank = b; in_pref = p; in_tag = g; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 in_ready", in_ready, 1);
    chk("R1 gnt_valid", gnt_valid, 0);

    for (int v = 0; v < 9; v++) begin
      do_reset();
      push(2'd3, 2'd3, 1'b0, 4'hF);   // blocker, becomes a batch of its own
      idle(2);
      push(VEC[v].at, 2'd0, VEC[v].ap, 4'd1);
      push(VEC[v].bt, 2'd0, VEC[v].bp, 4'd2);
      core_accurate = VEC[v].acc; core_light = VEC[v].lt; boost_en = VEC[v].bst;
      gnt_ready[3] = 1'b1;
      @(negedge clk);
      gnt_ready[3] = 1'b0;
      @(negedge clk);
      chk("R8 winner tag", gnt_tag[3:0], VEC[v].etag);
      chk("R8 winner marked", gnt_marked[0], VEC[v].emk);
    end

    // R4 per-thread cap of 2, then a fresh batch
    do_reset();
    push(2'd3, 2'd3, 1'b0, 4'hF);
    idle(2);
    push(2'd0, 2'd0, 1'b0, 4'd1);
    push(2'd0, 2'd0, 1'b0, 4'd2);
    push(2'd0, 2'd0, 1'b0, 4'd3);
    gnt_ready[3] = 1'b1;
    @(negedge clk);
    gnt_ready[3] = 1'b0;
    @(negedge clk);
    chk("R4 first tag", gnt_tag[3:0], 1);
    chk("R4 first marked", gnt_marked[0], 1);
    gnt_ready[0] = 1'b1;
    @(negedge clk);
    chk("R4 second marked", gnt_marked[0], 1);
    @(negedge clk);
    gnt_ready[0] = 1'b0;
    chk("R4 third tag", gnt_tag[3:0], 3);
    chk("R4 third beyond cap", gnt_marked[0], 0);
    @(negedge clk);
    chk("R4 new batch marks third", gnt_marked[0], 1);

    // R7 late arrival stays unmarked; R3 offer held without ready
    do_reset();
    push(2'd3, 2'd3, 1'b0, 4'hF);
    idle(2);
    push(2'd0, 2'd0, 1'b0, 4'd5);
    chk("R7 late arrival unmarked", gnt_marked[0], 0);
    idle(3);
    chk("R7 still unmarked", gnt_marked[0], 0);
    chk("R3 offer held", {gnt_valid[0], gnt_tag[3:0]}, {1'b1, 4'd5});

    // R10 same thread, two banks, same cycle
    do_reset();
    push(2'd1, 2'd0, 1'b0, 4'd1);
    push(2'd1, 2'd1, 1'b0, 4'd2);
    idle(2);
    chk("R10 both banks offered", gnt_valid[1:0], 2'b11);
    chk("R10 tags", gnt_tag[7:0], 8'h21);
    gnt_ready[1:0] = 2'b11;
    @(negedge clk);
    gnt_ready[1:0] = 2'b00;
    chk("R10 both retired together", gnt_valid, 0);

    // R2 fill to 16, extra push dropped, drain count
    do_reset();
    for (int i = 0; i < 16; i++) push(2'(i % 4), 2'd2, 1'b0, 4'(i));
    chk("R2 full backpressure", in_ready, 0);
    push(2'd0, 2'd1, 1'b0, 4'd0);
    idle(1);
    chk("R2 dropped push not offered", gnt_valid[1], 0);
    begin
      int cnt = 0;
      gnt_ready[2] = 1'b1;
      for (int k = 0; k < 40; k++) begin
        if (gnt_valid[2]) cnt++;
        @(negedge clk);
      end
      gnt_ready[2] = 1'b0;
      chk("R2 drained count", cnt, 16);
    end
    chk("R2 empty after drain", gnt_valid, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule